// File: doc/BRIEF.md
# Converter Result Register with Overrun Policy

This block sits between the conversion core of an analog-to-digital converter and the register file that software reads. Each time the core signals a finished sample, the block trims the sample to the active resolution, places it at the low or high end of a 16-bit data word, and holds it until software reads it. An end-of-conversion flag marks a result that has not been read yet.

A new sample that arrives while that flag is still up is an overrun. The block then raises a sticky overrun flag, and a configuration bit decides what happens to the data word: either the unread value stays and the new sample is lost, or the new sample replaces it. The policy bit may not change while a regular conversion runs. Resolution and alignment may not change while either a regular or an injected conversion runs. The block drops any write that breaks these rules.

Top module: `conv_result_reg`

## Requirements
- R1: After reset the data word is 0, both flags are clear, and the configuration is 12-bit, right aligned, with the keep-old-data policy (policy bit 0).
- R2: A result strobe while the end-of-conversion flag is clear loads the formatted sample into the data word and sets that flag, both visible one clock later.
- R3: A read strobe with no result strobe in the same cycle clears the end-of-conversion flag one clock later and leaves the data word unchanged.
- R4: A result strobe while the end-of-conversion flag is set, with no read in that cycle, sets the overrun flag one clock later. The end-of-conversion flag stays set.
- R5: With the policy bit at 0, an overrun leaves the data word holding the unread value.
- R6: With the policy bit at 1, an overrun replaces the data word with the newest formatted sample.
- R7: The overrun flag stays set until the clear strobe is pulsed. If a new overrun occurs in the same cycle as a clear, the flag stays set.
- R8: The 2-bit resolution code selects the sample width: 00 gives 12 bits, 01 gives 10, 10 gives 8 and 11 gives 6. The core's sample sits in the low bits of the raw input, and raw bits above the selected width are ignored.
- R9: With the alignment bit at 0, the sample's bit 0 lands at data bit 0 and every data bit above the sample width is 0.
- R10: With the alignment bit at 1, the sample's top bit lands at data bit 15 and every data bit below the sample is 0.
- R11: A configuration write while the regular-busy input is high does not change the policy bit. The injected-busy input alone does not block the policy bit.
- R12: A configuration write while either busy input is high does not change the resolution or the alignment.
- R13: A read strobe in the same cycle as a result strobe counts as consumed. The new sample loads, the end-of-conversion flag stays set, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid_i | input | 1 | One-cycle strobe: a new sample is on res_raw_i |
| res_raw_i | input | 12 | Sample from the core, right-justified |
| rd_i | input | 1 | Read strobe for the data word |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_overwrite_i | input | 1 | Overrun policy: 0 keeps old data, 1 overwrites |
| cfg_res_i | input | 2 | Resolution code |
| cfg_left_i | input | 1 | Alignment: 0 right, 1 left |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| reg_busy_i | input | 1 | A regular conversion is in progress |
| inj_busy_i | input | 1 | An injected conversion is in progress |
| data_o | output | 16 | Formatted data word |
| eoc_o | output | 1 | End-of-conversion flag: the data word holds an unread result |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The formatter is driven from a table that pairs every resolution code with both alignments. It uses a mixed-bit sample (0xABC), an all-ones sample and a single-bit sample. The mixed sample shows whether the correct raw bits are masked off at each width. The all-ones and single-bit samples expose an off-by-one in the shift amount or in the mask edge. Directed sequences then drive back-to-back strobes under each overrun policy, a clear and an overrun in the same cycle, and a read and a strobe in the same cycle. Configuration writes are made under each busy input on its own, so that the two lock scopes can be told apart.

// File: rtl/conv_result_pkg.sv
package conv_result_pkg;

   localparam int RES_STEP  = 2;
   localparam int SEL_W     = 2;
   localparam int NUM_RES   = 1 << SEL_W;

   typedef enum logic [SEL_W-1:0] {
      RES_W0 = 2'b00,
      RES_W1 = 2'b01,
      RES_W2 = 2'b10,
      RES_W3 = 2'b11
   } res_sel_e;

   typedef struct packed {
      logic     overwrite;
      res_sel_e res;
      logic     left;
   } fmt_cfg_t;

   function automatic int sel_width(input int raw_w, input res_sel_e sel);
      return raw_w - RES_STEP * int'(sel);
   endfunction

endpackage

// File: rtl/crr_cfg_lock.sv
module crr_cfg_lock
   import conv_result_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     we,
   input  fmt_cfg_t wr_cfg,
   input  logic     reg_busy,
   input  logic     inj_busy,
   output fmt_cfg_t cfg_q
);

   logic pol_open;
   logic fmt_open;

   assign pol_open = we && !reg_busy;
   assign fmt_open = we && !reg_busy && !inj_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.overwrite <= 1'b0;
         cfg_q.res       <= RES_W0;
         cfg_q.left      <= 1'b0;
      end else begin
         if (pol_open) begin
            cfg_q.overwrite <= wr_cfg.overwrite;
         end
         if (fmt_open) begin
            cfg_q.res  <= wr_cfg.res;
            cfg_q.left <= wr_cfg.left;
         end
      end
   end

   assert_policy_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_busy |=> $stable(cfg_q.overwrite));

   assert_format_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_busy || inj_busy) |=> ($stable(cfg_q.res) && $stable(cfg_q.left)));

endmodule

// File: rtl/crr_formatter.sv
module crr_formatter
   import conv_result_pkg::*;
#(
   parameter int RAW_W  = 12,
   parameter int DATA_W = 16
)(
   input  logic [RAW_W-1:0]  raw,
   input  res_sel_e          res,
   input  logic              left,
   output logic [DATA_W-1:0] word
);

   logic [DATA_W-1:0] cand_r [NUM_RES];
   logic [DATA_W-1:0] cand_l [NUM_RES];

   for (genvar k = 0; k < NUM_RES; k++) begin : g_width
      localparam int FW = RAW_W - RES_STEP * k;
      logic [FW-1:0] field;
      assign field     = raw[FW-1:0];
      assign cand_r[k] = DATA_W'(field);
      assign cand_l[k] = DATA_W'(field) << (DATA_W - FW);
   end

   always_comb begin
      if (left) begin
         word = cand_l[res];
      end else begin
         word = cand_r[res];
      end
   end

endmodule

// File: rtl/crr_data_hold.sv
module crr_data_hold #(
   parameter int DATA_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic [DATA_W-1:0] word,
   input  logic              rd,
   input  logic              ovr_clr,
   input  logic              overwrite,
   output logic [DATA_W-1:0] data_q,
   output logic              eoc_q,
   output logic              ovr_q
);

   logic ovr_evt;
   logic load;

   assign ovr_evt = valid && eoc_q && !rd;
   assign load    = valid && (!ovr_evt || overwrite);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (load) begin
         data_q <= word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc_q <= 1'b0;
      end else if (valid) begin
         eoc_q <= 1'b1;
      end else if (rd) begin
         eoc_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
      end else if (ovr_evt) begin
         ovr_q <= 1'b1;
      end else if (ovr_clr) begin
         ovr_q <= 1'b0;
      end
   end

   assert_strobe_sets_eoc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !eoc_q) |=> (eoc_q && data_q == $past(word)));

   assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !valid) |=> (!eoc_q && $stable(data_q)));

   assert_overrun_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && eoc_q && !rd) |=> (ovr_q && eoc_q));

   assert_keep_old_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && eoc_q && !rd && !overwrite) |=> $stable(data_q));

   assert_take_new_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && eoc_q && !rd && overwrite) |=> (data_q == $past(word)));

   assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !ovr_clr) |=> ovr_q);

   assert_read_with_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && rd && !ovr_q) |=> (!ovr_q && eoc_q));

endmodule

// File: rtl/conv_result_reg.sv
module conv_result_reg
   import conv_result_pkg::*;
#(
   parameter int RAW_W  = 12,
   parameter int DATA_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid_i,
   input  logic [RAW_W-1:0]  res_raw_i,
   input  logic              rd_i,
   input  logic              cfg_we_i,
   input  logic              cfg_overwrite_i,
   input  logic [SEL_W-1:0]  cfg_res_i,
   input  logic              cfg_left_i,
   input  logic              ovr_clr_i,
   input  logic              reg_busy_i,
   input  logic              inj_busy_i,
   output logic [DATA_W-1:0] data_o,
   output logic              eoc_o,
   output logic              ovr_o
);

   localparam int MIN_W = RAW_W - RES_STEP * (NUM_RES - 1);

   if (DATA_W < RAW_W) begin : g_bad_data_w
      $error("conv_result_reg: DATA_W must be at least RAW_W");
   end
   if (MIN_W < 1) begin : g_bad_raw_w
      $error("conv_result_reg: RAW_W too small for the narrowest resolution");
   end

   fmt_cfg_t          wr_cfg;
   fmt_cfg_t          cfg_q;
   logic [DATA_W-1:0] fmt_word;

   assign wr_cfg.overwrite = cfg_overwrite_i;
   assign wr_cfg.res       = res_sel_e'(cfg_res_i);
   assign wr_cfg.left      = cfg_left_i;

   crr_cfg_lock u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we_i),
      .wr_cfg   (wr_cfg),
      .reg_busy (reg_busy_i),
      .inj_busy (inj_busy_i),
      .cfg_q    (cfg_q)
   );

   crr_formatter #(
      .RAW_W  (RAW_W),
      .DATA_W (DATA_W)
   ) u_fmt (
      .raw  (res_raw_i),
      .res  (cfg_q.res),
      .left (cfg_q.left),
      .word (fmt_word)
   );

   crr_data_hold #(
      .DATA_W (DATA_W)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (res_valid_i),
      .word      (fmt_word),
      .rd        (rd_i),
      .ovr_clr   (ovr_clr_i),
      .overwrite (cfg_q.overwrite),
      .data_q    (data_o),
      .eoc_q     (eoc_o),
      .ovr_q     (ovr_o)
   );

   int                cur_w;
   logic [DATA_W-1:0] above_r;
   logic [DATA_W-1:0] below_l;

   assign cur_w   = sel_width(RAW_W, cfg_q.res);
   assign above_r = fmt_word >> cur_w;
   assign below_l = fmt_word << cur_w;

   assert_right_high_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q.left |-> (above_r == '0));

   assert_left_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.left |-> (below_l == '0));

endmodule

// File: tb/tb_conv_result_reg.sv
module tb_conv_result_reg;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [11:0] res_raw = '0;
   logic        rd = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_overwrite = 1'b0;
   logic [1:0]  cfg_res = 2'b00;
   logic        cfg_left = 1'b0;
   logic        ovr_clr = 1'b0;
   logic        reg_busy = 1'b0;
   logic        inj_busy = 1'b0;
   logic [15:0] data;
   logic        eoc;
   logic        ovr;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;

   always #10 clk = ~clk;

   conv_result_reg dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .res_valid_i     (res_valid),
      .res_raw_i       (res_raw),
      .rd_i            (rd),
      .cfg_we_i        (cfg_we),
      .cfg_overwrite_i (cfg_overwrite),
      .cfg_res_i       (cfg_res),
      .cfg_left_i      (cfg_left),
      .ovr_clr_i       (ovr_clr),
      .reg_busy_i      (reg_busy),
      .inj_busy_i      (inj_busy),
      .data_o          (data),
      .eoc_o           (eoc),
      .ovr_o           (ovr)
   );

   // {res[1:0], left, raw[11:0], expected[15:0]}
   localparam int NVEC = 12;
   localparam logic [30:0] VEC [NVEC] = '{
      {2'b00, 1'b0, 12'hABC, 16'h0ABC},
      {2'b00, 1'b1, 12'hABC, 16'hABC0},
      {2'b01, 1'b0, 12'hABC, 16'h02BC},
      {2'b01, 1'b1, 12'hABC, 16'hAF00},
      {2'b10, 1'b0, 12'hABC, 16'h00BC},
      {2'b10, 1'b1, 12'hABC, 16'hBC00},
      {2'b11, 1'b0, 12'hABC, 16'h003C},
      {2'b11, 1'b1, 12'hABC, 16'hF000},
      {2'b00, 1'b0, 12'hFFF, 16'h0FFF},
      {2'b11, 1'b1, 12'hFFF, 16'hFC00},
      {2'b10, 1'b1, 12'h001, 16'h0100},
      {2'b01, 1'b0, 12'hFFF, 16'h03FF}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
   endtask

   task automatic wr_cfg(input logic ow, input logic [1:0] r, input logic l);
      @(negedge clk);
      cfg_we = 1'b1; cfg_overwrite = ow; cfg_res = r; cfg_left = l;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic convert(input logic [11:0] v);
      @(negedge clk);
      res_valid = 1'b1; res_raw = v;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   task automatic do_read();
      @(negedge clk);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic clear_ovr();
      @(negedge clk);
      ovr_clr = 1'b1;
      @(negedge clk);
      ovr_clr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 data", data, 16'h0000);
      check("R1 eoc", {15'd0, eoc}, 16'h0000);
      check("R1 ovr", {15'd0, ovr}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset configuration: 12-bit right
      convert(12'hABC);
      check("R1 default format", data, 16'h0ABC);
      do_read();

      // table: R8 R9 R10 with R2 R3
      for (int i = 0; i < NVEC; i++) begin
         logic [30:0] v;
         v = VEC[i];
         wr_cfg(1'b0, v[30:29], v[28]);
         convert(v[27:16]);
         check("R8/R9/R10 format", data, v[15:0]);
         check("R2 eoc set", {15'd0, eoc}, 16'h0001);
         do_read();
         check("R3 eoc cleared", {15'd0, eoc}, 16'h0000);
         check("R3 data held", data, v[15:0]);
      end

      // R4 R5 keep policy
      wr_cfg(1'b0, 2'b00, 1'b0);
      convert(12'h111);
      convert(12'h222);
      check("R4 ovr set", {15'd0, ovr}, 16'h0001);
      check("R4 eoc kept", {15'd0, eoc}, 16'h0001);
      check("R5 old data kept", data, 16'h0111);

      // R7 sticky then clear
      do_read();
      repeat (3) @(negedge clk);
      check("R7 ovr sticky", {15'd0, ovr}, 16'h0001);
      clear_ovr();
      check("R7 ovr cleared", {15'd0, ovr}, 16'h0000);

      // R6 overwrite policy
      wr_cfg(1'b1, 2'b00, 1'b0);
      convert(12'h333);
      convert(12'h444);
      check("R6 new data", data, 16'h0444);
      check("R6 ovr set", {15'd0, ovr}, 16'h0001);

      // R7 clear and overrun in one cycle
      clear_ovr();
      @(negedge clk);
      ovr_clr = 1'b1; res_valid = 1'b1; res_raw = 12'h555;
      @(negedge clk);
      ovr_clr = 1'b0; res_valid = 1'b0;
      check("R7 set wins over clear", {15'd0, ovr}, 16'h0001);
      check("R6 data on overrun", data, 16'h0555);
      clear_ovr();
      do_read();

      // R13 read with strobe
      convert(12'h666);
      @(negedge clk);
      rd = 1'b1; res_valid = 1'b1; res_raw = 12'h777;
      @(negedge clk);
      rd = 1'b0; res_valid = 1'b0;
      check("R13 data loaded", data, 16'h0777);
      check("R13 eoc set", {15'd0, eoc}, 16'h0001);
      check("R13 no overrun", {15'd0, ovr}, 16'h0000);
      do_read();

      // R11 policy locked by regular busy
      reg_busy = 1'b1;
      wr_cfg(1'b0, 2'b00, 1'b0);
      reg_busy = 1'b0;
      convert(12'h0A1);
      convert(12'h0A2);
      check("R11 policy unchanged", data, 16'h00A2);
      clear_ovr();
      do_read();
      // R11 injected busy alone does not block policy
      inj_busy = 1'b1;
      wr_cfg(1'b0, 2'b00, 1'b0);
      inj_busy = 1'b0;
      convert(12'h0B1);
      convert(12'h0B2);
      check("R11 policy written", data, 16'h00B1);
      clear_ovr();
      do_read();

      // R12 format locked by either busy
      reg_busy = 1'b1;
      wr_cfg(1'b0, 2'b11, 1'b1);
      reg_busy = 1'b0;
      convert(12'hABC);
      check("R12 locked by regular", data, 16'h0ABC);
      do_read();
      inj_busy = 1'b1;
      wr_cfg(1'b0, 2'b10, 1'b1);
      inj_busy = 1'b0;
      convert(12'hABC);
      check("R12 locked by injected", data, 16'h0ABC);
      do_read();
      wr_cfg(1'b0, 2'b10, 1'b1);
      convert(12'hABC);
      check("R12 write when idle", data, 16'hBC00);
      do_read();

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule